// File: doc/BRIEF.md
# Quad-channel serial DAC write front end

This block is the digital front end of a four-channel digital-to-analog converter. A host writes 24-bit words over a three-wire serial link: an active-low frame select, a serial clock and a data line. The block oversamples all three wires with a fast system clock. It assembles each complete frame and decodes it into a command, a channel address and a 16-bit data field. It then updates a two-stage register pair per channel: a staged input value, and the code that drives the converter. The analog converters, output amplifiers and the voltage reference lie outside this block. It delivers only their digital controls: four converter codes, a 2-bit power-down mode per channel and a reference-enable flag.

A frame that the host cuts short by raising frame select before the 24th falling clock edge leaves every register untouched. The channel width is a parameter. Narrower channels take the upper bits of the 16-bit data field.

Top module: `qdac_serial_front`

## Requirements
- R1: After reset, every converter code is zero, every channel's power-down mode is 00 (normal), and the reference-enable flag is 0.
- R2: While frame select is low, one data bit is taken on each falling edge of the serial clock, most significant bit first. Of the 24-bit word, bits 21:19 hold the command, bits 18:16 the address and bits 15:0 the data. Bits 23:22 have no effect.
- R3: If frame select rises before the 24th falling clock edge of a frame, no output and no stored value changes.
- R4: Falling clock edges after the 24th within the same frame are ignored, so one frame makes at most one write.
- R5: Command 000 loads the data into the input register of each addressed channel and leaves the converter codes unchanged.
- R6: Command 001 copies the input register of each addressed channel into its converter code. The data field is ignored.
- R7: Command 010 loads the data into the input register of each addressed channel, then updates the converter codes of all channels from their input registers.
- R8: Command 011 loads the data into both the input register and the converter code of each addressed channel.
- R9: Addresses 000 to 011 select channels 0 to 3. Address 111 selects all channels. Addresses 100 to 110 select none.
- R10: Command 100 sets the power-down mode of every channel whose bit is set in data bits 3:0 (bit i is channel i) to data bits 5:4. The modes are 00 normal, 01 1 kΩ to ground, 10 100 kΩ to ground and 11 floating. Unmasked channels keep their mode.
- R11: Command 101 returns all input registers, converter codes, power-down modes and the reference flag to their reset values.
- R12: Command 110 sets the reference-enable flag to data bit 0, and nothing else sets it. Command 111 changes nothing.
- R13: With a channel width below 16, a channel code is the upper CH_BITS bits of the data field.
- R14: A write reaches the outputs at the fourth rising system-clock edge after the 24th falling serial-clock edge appears at the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data, most significant bit first |
| dac_code | output | NUM_CH x CH_BITS | Converter code for each channel |
| pd_mode | output | NUM_CH x 2 | Power-down mode for each channel |
| ref_en | output | 1 | Internal reference enable |

## Verification
A wrong bit count or an early-terminated frame slipping through would show as an output changing after a short frame, or a code landing one bit shifted. Either appears within four system clocks of the offending serial edge. Staged input values are not visible directly. A corrupted input register therefore shows only at the next update command, so the bench follows every staging write with an update and compares all converter codes. The reference model runs on the raw pins, and every clock its state is compared with the outputs, delayed by the fixed pipeline depth. A latency error of even one cycle fails immediately.

// File: rtl/qdac_pkg.sv
// Shared constants and encodings for the serial DAC front end.
package qdac_pkg;
    localparam int FRAME_BITS   = 24;   // serial edges per frame
    localparam int PAYLOAD_BITS = 22;   // low bits kept; top two are don't-care
    localparam int CMD_LSB      = 19;
    localparam int ADDR_LSB     = 16;
    localparam int DATA_BITS    = 16;
    localparam int PD_MODE_LSB  = 4;    // power-down mode field in data
    localparam logic [2:0] ADDR_ALL = 3'b111;

    typedef enum logic [2:0] {
        CMD_WR_IN      = 3'd0,
        CMD_UPDATE     = 3'd1,
        CMD_WR_UPD_ALL = 3'd2,
        CMD_WR_UPD     = 3'd3,
        CMD_PWRDN      = 3'd4,
        CMD_SWRST      = 3'd5,
        CMD_REF        = 3'd6,
        CMD_NOP        = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        PD_NORMAL = 2'd0,
        PD_1K     = 2'd1,
        PD_100K   = 2'd2,
        PD_FLOAT  = 2'd3
    } pd_mode_e;
endpackage

// File: rtl/qdac_pin_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; alignment between bits holds because
// all bits pass the same number of stages.
module qdac_pin_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Each stage re-registers the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n)      stg[s] <= RST_VAL;
            else if (s == 0) stg[s] <= raw;
            else             stg[s] <= stg[(s == 0) ? 0 : s-1];
        end
    end

    assign synced = stg[STAGES-1];
endmodule

// File: rtl/qdac_frame_rx.sv
// Frame receiver: detects falling edges of the synchronized serial clock
// and frame select, shifts in up to FRAME_BITS data bits and emits one
// payload word when exactly the last bit arrives inside an open frame.
// Assumes the inputs are already synchronized and at most one serial
// clock edge occurs per system clock.
module qdac_frame_rx
    import qdac_pkg::*;
#(
    localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sclk_s,
    input  logic                    sel_s,
    input  logic                    din_s,
    output logic                    word_valid,
    output logic [PAYLOAD_BITS-1:0] word,
    output logic [CNT_W-1:0]        bit_cnt
);
    logic                    sclk_q;
    logic                    sel_q;
    logic                    active;
    logic [PAYLOAD_BITS-1:0] shreg;
    logic                    sclk_fall;
    logic                    sel_fall;

    assign sclk_fall = sclk_q & ~sclk_s;
    assign sel_fall  = sel_q & ~sel_s;

    // Previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sel_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            sel_q  <= sel_s;
        end
    end

    // Frame state, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            word_valid <= 1'b0;
            word       <= '0;
        end else begin
            word_valid <= 1'b0;
            if (sel_s) begin
                active <= 1'b0;
            end else if (sel_fall) begin
                active  <= 1'b1;
                bit_cnt <= '0;
            end else if (active && sclk_fall && bit_cnt != CNT_W'(FRAME_BITS)) begin
                shreg   <= {shreg[PAYLOAD_BITS-2:0], din_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
                    word_valid <= 1'b1;
                    word       <= {shreg[PAYLOAD_BITS-2:0], din_s};
                end
            end
        end
    end
endmodule

// File: rtl/qdac_chan_bank.sv
// Channel register bank: decodes a payload word and updates the per-channel
// input registers, converter codes and power-down modes, plus the shared
// reference flag. Assumes NUM_CH <= 4 (mask field is data bits 3:0).
module qdac_chan_bank
    import qdac_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int CH_BITS = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           word_valid,
    input  logic [PAYLOAD_BITS-1:0]        word,
    output logic [NUM_CH-1:0][CH_BITS-1:0] dac_code,
    output logic [NUM_CH-1:0][1:0]         pd_mode,
    output logic                           ref_en
);
    cmd_e                 cmd;
    logic [2:0]           addr;
    logic [DATA_BITS-1:0] data;
    logic [CH_BITS-1:0]   code_in;
    logic [1:0]           pd_req;
    logic                 clear;

    assign cmd     = cmd_e'(word[CMD_LSB +: 3]);
    assign addr    = word[ADDR_LSB +: 3];
    assign data    = word[DATA_BITS-1:0];
    assign code_in = data[DATA_BITS-1 -: CH_BITS];
    assign pd_req  = data[PD_MODE_LSB +: 2];
    assign clear   = !rst_n || (word_valid && cmd == CMD_SWRST);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [CH_BITS-1:0] in_reg;
        logic               hit;

        assign hit = (addr == ADDR_ALL) || (addr == 3'(ch));

        // Two-stage load: staged input value and live converter code.
        always_ff @(posedge clk) begin
            if (clear) begin
                in_reg       <= '0;
                dac_code[ch] <= '0;
            end else if (word_valid) begin
                case (cmd)
                    CMD_WR_IN: begin
                        if (hit) in_reg <= code_in;
                    end
                    CMD_UPDATE: begin
                        if (hit) dac_code[ch] <= in_reg;
                    end
                    CMD_WR_UPD_ALL: begin
                        if (hit) begin
                            in_reg       <= code_in;
                            dac_code[ch] <= code_in;
                        end else begin
                            dac_code[ch] <= in_reg;
                        end
                    end
                    CMD_WR_UPD: begin
                        if (hit) begin
                            in_reg       <= code_in;
                            dac_code[ch] <= code_in;
                        end
                    end
                    default: ;
                endcase
            end
        end

        // Power-down mode, changed only by a masked power-down command.
        always_ff @(posedge clk) begin
            if (clear)
                pd_mode[ch] <= PD_NORMAL;
            else if (word_valid && cmd == CMD_PWRDN && data[ch])
                pd_mode[ch] <= pd_req;
        end
    end

    // Reference enable, off after any reset.
    always_ff @(posedge clk) begin
        if (clear)
            ref_en <= 1'b0;
        else if (word_valid && cmd == CMD_REF)
            ref_en <= data[0];
    end
endmodule

// File: rtl/qdac_serial_front.sv
// Top of the serial DAC front end. Synchronizes the three serial pins to
// clk, receives 24-bit frames and applies them to the channel bank.
// Assumes clk runs at least four times the serial clock rate and that
// frame select is high for at least one serial clock period between frames.
module qdac_serial_front
    import qdac_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CH_BITS     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ser_clk,
    input  logic                           ser_sel_n,
    input  logic                           ser_din,
    output logic [NUM_CH-1:0][CH_BITS-1:0] dac_code,
    output logic [NUM_CH-1:0][1:0]         pd_mode,
    output logic                           ref_en
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    logic [2:0]              pins_s;
    logic                    frm_valid;
    logic [PAYLOAD_BITS-1:0] frm_word;
    logic [CNT_W-1:0]        bit_cnt;
    logic                    sel_lvl;

    assign sel_lvl = pins_s[1];

    qdac_pin_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({ser_din, ser_sel_n, ser_clk}),
        .synced (pins_s)
    );

    qdac_frame_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (pins_s[0]),
        .sel_s      (pins_s[1]),
        .din_s      (pins_s[2]),
        .word_valid (frm_valid),
        .word       (frm_word),
        .bit_cnt    (bit_cnt)
    );

    qdac_chan_bank #(
        .NUM_CH  (NUM_CH),
        .CH_BITS (CH_BITS)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (frm_valid),
        .word       (frm_word),
        .dac_code   (dac_code),
        .pd_mode    (pd_mode),
        .ref_en     (ref_en)
    );
endmodule

// File: rtl/qdac_serial_front_chk.sv
// Assertion checker for qdac_serial_front, attached by bind below.
module qdac_serial_front_chk
    import qdac_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int CH_BITS = 16,
    localparam int CNT_W  = $clog2(FRAME_BITS + 1)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        frm_valid,
    input logic [PAYLOAD_BITS-1:0]     frm_word,
    input logic [CNT_W-1:0]            bit_cnt,
    input logic                        sel_lvl,
    input logic [NUM_CH*CH_BITS-1:0]   dac_flat,
    input logic [NUM_CH*2-1:0]         pd_flat,
    input logic                        ref_en
);
    // R1: values right after reset release
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_flat == '0 && pd_flat == '0 && !ref_en));

    // R3: a word is emitted only after the last bit of an open frame
    p_full_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> ($past(bit_cnt) == CNT_W'(FRAME_BITS - 1) && !$past(sel_lvl)));

    // R3: outputs hold still unless a word was just emitted
    p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frm_valid) |-> ($stable(dac_flat) && $stable(pd_flat) && $stable(ref_en)));

    // R4: the bit counter never passes the frame length
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_BITS));

    // R4: one word per frame, never back to back
    p_single_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid);

    // R12: the reference turns on only through its command
    p_ref_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_en) |-> $past(frm_word[CMD_LSB +: 3]) == CMD_REF);
endmodule

bind qdac_serial_front qdac_serial_front_chk #(
    .NUM_CH  (NUM_CH),
    .CH_BITS (CH_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_valid (frm_valid),
    .frm_word  (frm_word),
    .bit_cnt   (bit_cnt),
    .sel_lvl   (sel_lvl),
    .dac_flat  (dac_code),
    .pd_flat   (pd_mode),
    .ref_en    (ref_en)
);

// File: tb/qdac_serial_front_tb.sv
// Bench: behavioural pin-level model compared every clock, plus directed checks.
module qdac_serial_front_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;    // queue depth matching the output latency

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic sel_n = 1'b1;
    logic din = 1'b0;

    logic [3:0][15:0] dac_code;
    logic [3:0][1:0]  pd_mode;
    logic             ref_en;
    logic [3:0][11:0] n_code;
    logic [3:0][1:0]  n_pd;
    logic             n_ref;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdac_serial_front u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_sel_n(sel_n), .ser_din(din),
        .dac_code(dac_code), .pd_mode(pd_mode), .ref_en(ref_en));

    qdac_serial_front #(.CH_BITS(12)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_sel_n(sel_n), .ser_din(din),
        .dac_code(n_code), .pd_mode(n_pd), .ref_en(n_ref));

    // ---------------- reference model on the raw pins ----------------
    logic [15:0] m_in  [4];
    logic [15:0] m_dac [4];
    logic [1:0]  m_pd  [4];
    logic        m_ref;
    logic        m_psclk, m_psel, m_act;
    int          m_cnt;
    logic [23:0] m_sh;
    logic [72:0] mq [$];

    function automatic logic [72:0] m_snap();
        return {m_ref, m_pd[3], m_pd[2], m_pd[1], m_pd[0],
                m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
    endfunction

    task automatic m_clear();
        for (int c = 0; c < 4; c++) begin
            m_in[c] = '0; m_dac[c] = '0; m_pd[c] = '0;
        end
        m_ref = 1'b0;
    endtask

    task automatic m_apply(input logic [23:0] w);
        logic [2:0]  op   = w[21:19];
        logic [2:0]  ad   = w[18:16];
        logic [15:0] d    = w[15:0];
        for (int c = 0; c < 4; c++) begin
            bit hit = (ad == 3'd7) || (int'(ad) == c);
            case (op)
                3'd0: if (hit) m_in[c] = d;
                3'd1: if (hit) m_dac[c] = m_in[c];
                3'd2: begin if (hit) m_in[c] = d; m_dac[c] = m_in[c]; end
                3'd3: if (hit) begin m_in[c] = d; m_dac[c] = d; end
                3'd4: if (d[c]) m_pd[c] = d[5:4];
                default: ;
            endcase
        end
        if (op == 3'd5) m_clear();
        if (op == 3'd6) m_ref = d[0];
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_clear();
            m_psclk = 1'b0; m_psel = 1'b1; m_act = 1'b0; m_cnt = 0; m_sh = '0;
            mq.delete();
            for (int k = 0; k < LAT; k++) mq.push_back(m_snap());
        end else begin
            if (sel_n) m_act = 1'b0;
            else if (m_psel) begin m_act = 1'b1; m_cnt = 0; end
            else if (m_act && m_psclk && !sclk && m_cnt < 24) begin
                m_sh = {m_sh[22:0], din};
                m_cnt++;
                if (m_cnt == 24) m_apply(m_sh);
            end
            m_psclk = sclk;
            m_psel  = sel_n;
            mq.push_back(m_snap());
            while (mq.size() > LAT) void'(mq.pop_front());
        end
    end

    // R14: every clock, outputs equal the model delayed by the pipeline depth
    always @(negedge clk) begin
        if (rst_n && mq.size() == LAT && !done) begin
            total++;
            if ({ref_en, pd_mode, dac_code} !== mq[0]) begin
                bad++;
                $display("FAIL R14 model compare t=%0t act=%h exp=%h",
                         $time, {ref_en, pd_mode, dac_code}, mq[0]);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] fr(input logic [1:0] top, input logic [2:0] op,
                                      input logic [2:0] ad, input logic [15:0] d);
        return {top, op, ad, d};
    endfunction

    // Sends n bits of w (MSB first); lat_ch >= 0 checks exact output latency.
    task automatic send(input logic [31:0] w, input int n,
                        input int lat_ch = -1, input logic [15:0] lat_new = '0);
        @(negedge clk);
        sel_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            din = w[n-1-i];
            repeat (3) @(negedge clk);
            sclk = 1'b0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (i == 23 && lat_ch >= 0 && k == 2)
                    chk(dac_code[lat_ch] != lat_new, "R14 early", dac_code[lat_ch], lat_new);
            end
            sclk = 1'b1;
        end
        if (lat_ch >= 0) begin
            @(negedge clk);
            chk(dac_code[lat_ch] == lat_new, "R14 on time", dac_code[lat_ch], lat_new);
        end
        repeat (2) @(negedge clk);
        sel_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        hw_reset();
        chk(dac_code == '0, "R1 codes", dac_code[0], 0);
        chk(pd_mode == '0,  "R1 pd", pd_mode, 0);
        chk(ref_en == 1'b0, "R1 ref", ref_en, 0);

        send(fr(2'b00, 3'd0, 3'd1, 16'h1234), 24);
        chk(dac_code[1] == 16'h0, "R5 staged only", dac_code[1], 0);

        send(fr(2'b00, 3'd1, 3'd1, 16'hFFFF), 24);
        chk(dac_code[1] == 16'h1234, "R6 update", dac_code[1], 16'h1234);

        send(fr(2'b11, 3'd3, 3'd2, 16'hBEEF), 24, 2, 16'hBEEF);
        chk(dac_code[2] == 16'hBEEF, "R8 R2 write+update", dac_code[2], 16'hBEEF);

        send(fr(2'b00, 3'd3, 3'd0, 16'h5555), 20);
        chk(dac_code[0] == 16'h0, "R3 abort at 20", dac_code[0], 0);
        send(fr(2'b00, 3'd3, 3'd0, 16'h5555) >> 1, 23);
        chk(dac_code[0] == 16'h0, "R3 abort at 23", dac_code[0], 0);

        send({4'h0, fr(2'b00, 3'd3, 3'd3, 16'h0F0F), 4'hF}, 28);
        chk(dac_code[3] == 16'h0F0F, "R4 extra edges", dac_code[3], 16'h0F0F);

        send(fr(2'b00, 3'd0, 3'd7, 16'h2222), 24);
        chk(dac_code[0] == 16'h0, "R9 all staged", dac_code[0], 0);
        send(fr(2'b00, 3'd2, 3'd0, 16'h3333), 24);
        chk(dac_code[0] == 16'h3333, "R7 ch0", dac_code[0], 16'h3333);
        chk(dac_code[2] == 16'h2222, "R7 R9 ch2", dac_code[2], 16'h2222);
        chk(dac_code[3] == 16'h2222, "R7 R9 ch3", dac_code[3], 16'h2222);

        send(fr(2'b00, 3'd3, 3'd5, 16'h7777), 24);
        chk(dac_code == {16'h2222, 16'h2222, 16'h2222, 16'h3333}, "R9 no channel",
            dac_code[0], 16'h3333);

        send(fr(2'b00, 3'd4, 3'd0, 16'h0025), 24);
        chk(pd_mode == {2'd0, 2'd2, 2'd0, 2'd2}, "R10 mask 0101", pd_mode, 8'h22);
        send(fr(2'b00, 3'd4, 3'd0, 16'h0038), 24);
        chk(pd_mode == {2'd3, 2'd2, 2'd0, 2'd2}, "R10 mask 1000", pd_mode, 8'hE2);

        send(fr(2'b00, 3'd6, 3'd0, 16'h0001), 24);
        chk(ref_en == 1'b1, "R12 ref on", ref_en, 1);
        send(fr(2'b00, 3'd7, 3'd7, 16'hFFFF), 24);
        chk(ref_en == 1'b1 && dac_code[0] == 16'h3333, "R12 nop", dac_code[0], 16'h3333);

        send(fr(2'b00, 3'd3, 3'd0, 16'hABCD), 24);
        chk(n_code[0] == 12'hABC, "R13 narrow ch0", n_code[0], 12'hABC);
        chk(n_code[1] == 12'h222, "R13 narrow ch1", n_code[1], 12'h222);

        send(fr(2'b00, 3'd5, 3'd0, 16'h0000), 24);
        chk(dac_code == '0 && pd_mode == '0 && !ref_en, "R11 soft reset",
            {ref_en, pd_mode, dac_code[0]}, 0);
        chk(n_code == '0, "R11 narrow", n_code[0], 0);

        send(fr(2'b00, 3'd3, 3'd1, 16'h4444), 24);
        chk(dac_code[1] == 16'h4444, "R8 before reset", dac_code[1], 16'h4444);
        hw_reset();
        chk(dac_code == '0 && pd_mode == '0 && !ref_en, "R1 after reset",
            dac_code[1], 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule